// File: doc/BRIEF.md
# Display Clear and Reset Sequencer

This block clears the internal memories of a character display controller. Two events start the same short write sweep. The first is a host write to the control register with the clear bit (bit 7) set. The second is the release of the active-low reset input. The sweep fills every character location with the space code 20h and every flash-attribute location with 0. Groups of locations are written in parallel so that the whole memory is covered in a fixed number of cycles.

The two triggers differ in what they keep. A clear keeps the other control bits and clears only its own bit when the sweep ends. A reset zeros the whole control register and restarts the display scan counter. Neither trigger touches the user-defined-character address register. The block raises a busy flag for the length of the sweep and drops host writes while that flag is high. The memories sit outside the block and see only per-location write enables plus shared write data.

Top module: `disp_clr_seq`

## Requirements
- R1: While rst_ni is low, busy_o is 1, ctrl_o is 0 and scan_o is 0.
- R2: After rst_ni rises, the sweep runs for exactly three cycles. In sweep cycle k (k = 0, 1, 2) char_we_o and flash_we_o both assert exactly the locations whose index divided by 3 equals k: masks 07h, 38h, C0h. During the sweep char_wdata_o is 20h and flash_wdata_o is 0. busy_o falls at the clock edge that ends the third cycle.
- R3: wr_sel_i selects the target of a host write: 0 control register, 1 character RAM, 2 flash RAM, 3 UDC address register. A host control write with wr_data_i bit 7 set, made while not busy, loads the control register and raises busy_o at that edge. The three-cycle sweep of R2 follows.
- R4: On the edge that ends a clear sweep, control bit 7 returns to 0. The other control bits keep the value that was written.
- R5: A clear leaves the UDC address register unchanged and does not disturb the scan counter.
- R6: A reset leaves the UDC address register unchanged.
- R7: While busy_o is high, host writes have no effect. No write enable is added to the sweep, and neither register changes.
- R8: A clear request made during reset or during the reset sweep is dropped. After the sweep, ctrl_o is 0.
- R9: A host write to the character or flash RAM while idle asserts only the enable bit at wr_addr_i. Character data is wr_data_i. Flash data is wr_data_i bit 0.
- R10: scan_o is 0 on reset release and increases by 1 on every clock edge, wrapping at its width.
- R11: Once a sweep has finished, every character location holds 20h and every flash location holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; its release starts a sweep |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Host write target |
| wr_addr_i | input | 3 | Host RAM location |
| wr_data_i | input | 8 | Host write data |
| char_we_o | output | 8 | Per-location character RAM write enables |
| char_wdata_o | output | 8 | Character RAM write data |
| flash_we_o | output | 8 | Per-location flash RAM write enables |
| flash_wdata_o | output | 1 | Flash RAM write data |
| ctrl_o | output | 8 | Control register |
| udc_addr_o | output | 4 | UDC address register |
| scan_o | output | 3 | Display scan counter |
| busy_o | output | 1 | Sweep in progress |

## Verification
The assertions assume that rst_ni is released away from a clock edge. They also assume that host strobes are sampled only at rising edges, so the control write that starts a clear is visible in the cycle before busy_o rises. The bench drives every input on the falling edge, including the reset release. This keeps each trigger one clean cycle ahead of the edge that acts on it. Host writes issued during busy are placed on purpose in different sweep cycles, so the assertions on dropped writes see real traffic.

// File: rtl/disp_clr_pkg.sv
package disp_clr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_CHAR  = 2'd1,
    SEL_FLASH = 2'd2,
    SEL_UDC   = 2'd3
  } wr_sel_e;

  localparam logic [7:0] SPACE_CODE = 8'h20;
  localparam int         CLR_BIT    = 7;
endpackage

// File: rtl/disp_clr_fsm.sv
module disp_clr_fsm #(
  parameter int SWEEP_CYC = 3,
  parameter int PH_W      = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            active_o,
  output logic [PH_W-1:0] phase_o,
  output logic            done_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SWEEP_CYC - 1);

  logic            active_q;
  logic [PH_W-1:0] phase_q;

  // reset parks the sweep at phase 0 so it runs on release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      phase_q  <= '0;
    end else if (active_q) begin
      if (phase_q == LAST) begin
        active_q <= 1'b0;
        phase_q  <= '0;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end else if (start_i) begin
      active_q <= 1'b1;
      phase_q  <= '0;
    end
  end

  assign active_o = active_q;
  assign phase_o  = phase_q;
  assign done_o   = active_q && (phase_q == LAST);
endmodule

// File: rtl/disp_clr_regs.sv
module disp_clr_regs
  import disp_clr_pkg::*;
#(
  parameter int UDC_W  = 4,
  parameter int SCAN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_ok_i,
  input  wr_sel_e           sel_i,
  input  logic [7:0]        data_i,
  input  logic              done_i,
  output logic [7:0]        ctrl_o,
  output logic [UDC_W-1:0]  udc_o,
  output logic [SCAN_W-1:0] scan_o,
  output logic              clr_start_o
);
  logic [7:0]        ctrl_q;
  logic [UDC_W-1:0]  udc_q;
  logic [SCAN_W-1:0] scan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (host_ok_i && sel_i == SEL_CTRL) begin
      ctrl_q <= data_i;
    end else if (done_i) begin
      ctrl_q[CLR_BIT] <= 1'b0;
    end
  end

  // survives reset by design
  always_ff @(posedge clk_i) begin
    if (host_ok_i && sel_i == SEL_UDC) udc_q <= data_i[UDC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scan_q <= '0;
    else         scan_q <= scan_q + 1'b1;
  end

  assign clr_start_o = host_ok_i && (sel_i == SEL_CTRL) && data_i[CLR_BIT];
  assign ctrl_o      = ctrl_q;
  assign udc_o       = udc_q;
  assign scan_o      = scan_q;
endmodule

// File: rtl/disp_clr_wport.sv
module disp_clr_wport
  import disp_clr_pkg::*;
#(
  parameter int N_LOC       = 8,
  parameter int ADDR_W      = 3,
  parameter int LOC_PER_CYC = 3,
  parameter int PH_W        = 2
) (
  input  logic              sweep_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              host_ok_i,
  input  wr_sel_e           sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [N_LOC-1:0]  char_we_o,
  output logic [7:0]        char_wdata_o,
  output logic [N_LOC-1:0]  flash_we_o,
  output logic              flash_wdata_o
);
  logic host_char, host_flash;

  assign host_char  = host_ok_i && (sel_i == SEL_CHAR);
  assign host_flash = host_ok_i && (sel_i == SEL_FLASH);

  for (genvar i = 0; i < N_LOC; i++) begin : g_loc
    logic sweep_hit, addr_hit;
    assign sweep_hit     = sweep_i && ((i / LOC_PER_CYC) == int'(phase_i));
    assign addr_hit      = (addr_i == ADDR_W'(i));
    assign char_we_o[i]  = sweep_hit || (host_char && addr_hit);
    assign flash_we_o[i] = sweep_hit || (host_flash && addr_hit);
  end

  assign char_wdata_o  = sweep_i ? SPACE_CODE : data_i;
  assign flash_wdata_o = sweep_i ? 1'b0 : data_i[0];
endmodule

// File: rtl/disp_clr_seq.sv
module disp_clr_seq
  import disp_clr_pkg::*;
#(
  parameter int N_LOC     = 8,
  parameter int SWEEP_CYC = 3,
  parameter int UDC_W     = 4,
  parameter int SCAN_W    = 3,
  localparam int ADDR_W      = $clog2(N_LOC),
  localparam int PH_W        = (SWEEP_CYC > 1) ? $clog2(SWEEP_CYC) : 1,
  localparam int LOC_PER_CYC = (N_LOC + SWEEP_CYC - 1) / SWEEP_CYC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [N_LOC-1:0]  char_we_o,
  output logic [7:0]        char_wdata_o,
  output logic [N_LOC-1:0]  flash_we_o,
  output logic              flash_wdata_o,
  output logic [7:0]        ctrl_o,
  output logic [UDC_W-1:0]  udc_addr_o,
  output logic [SCAN_W-1:0] scan_o,
  output logic              busy_o
);
  logic            active, done, clr_start, host_ok;
  logic [PH_W-1:0] phase;
  wr_sel_e         sel;

  assign sel     = wr_sel_e'(wr_sel_i);
  assign host_ok = wr_en_i && !active;
  assign busy_o  = active;

  disp_clr_fsm #(.SWEEP_CYC(SWEEP_CYC), .PH_W(PH_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (clr_start),
    .active_o(active),
    .phase_o (phase),
    .done_o  (done)
  );

  disp_clr_regs #(.UDC_W(UDC_W), .SCAN_W(SCAN_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .host_ok_i  (host_ok),
    .sel_i      (sel),
    .data_i     (wr_data_i),
    .done_i     (done),
    .ctrl_o     (ctrl_o),
    .udc_o      (udc_addr_o),
    .scan_o     (scan_o),
    .clr_start_o(clr_start)
  );

  disp_clr_wport #(
    .N_LOC(N_LOC), .ADDR_W(ADDR_W), .LOC_PER_CYC(LOC_PER_CYC), .PH_W(PH_W)
  ) u_wport (
    .sweep_i      (active),
    .phase_i      (phase),
    .host_ok_i    (host_ok),
    .sel_i        (sel),
    .addr_i       (wr_addr_i),
    .data_i       (wr_data_i),
    .char_we_o    (char_we_o),
    .char_wdata_o (char_wdata_o),
    .flash_we_o   (flash_we_o),
    .flash_wdata_o(flash_wdata_o)
  );
endmodule

// File: rtl/disp_clr_seq_chk.sv
module disp_clr_seq_chk #(
  parameter int N_LOC     = 8,
  parameter int SWEEP_CYC = 3,
  parameter int UDC_W     = 4,
  parameter int SCAN_W    = 3,
  parameter int ADDR_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [N_LOC-1:0]  char_we_o,
  input logic [7:0]        char_wdata_o,
  input logic [N_LOC-1:0]  flash_we_o,
  input logic              flash_wdata_o,
  input logic [7:0]        ctrl_o,
  input logic [UDC_W-1:0]  udc_addr_o,
  input logic [SCAN_W-1:0] scan_o,
  input logic              busy_o
);
  logic [7:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_rst_state_r1: assert (busy_o && ctrl_o == '0 && scan_o == '0);
    end
  end

  p_sweep_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_cnt < 8'(SWEEP_CYC));

  p_sweep_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (char_wdata_o == 8'h20 && !flash_wdata_o && char_we_o == flash_we_o
                && char_we_o != '0));

  p_clr_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i && wr_sel_i == 2'd0 && wr_data_i[7]));

  p_clr_bit_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !ctrl_o[7]);

  p_udc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(udc_addr_o));

  p_ctrl_low_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ctrl_o[6:0] == $past(ctrl_o[6:0]));

  p_host_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ($onehot0(char_we_o) && $onehot0(flash_we_o)));

  p_scan_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> scan_o == SCAN_W'($past(scan_o) + 1'b1));
endmodule

bind disp_clr_seq disp_clr_seq_chk #(
  .N_LOC(N_LOC), .SWEEP_CYC(SWEEP_CYC), .UDC_W(UDC_W), .SCAN_W(SCAN_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .char_we_o    (char_we_o),
  .char_wdata_o (char_wdata_o),
  .flash_we_o   (flash_we_o),
  .flash_wdata_o(flash_wdata_o),
  .ctrl_o       (ctrl_o),
  .udc_addr_o   (udc_addr_o),
  .scan_o       (scan_o),
  .busy_o       (busy_o)
);

// File: tb/disp_clr_seq_bench.sv
module disp_clr_seq_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = 2'd0;
  logic [2:0] wr_addr_i = 3'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [7:0] char_we_o, char_wdata_o, flash_we_o, ctrl_o;
  logic       flash_wdata_o, busy_o;
  logic [3:0] udc_addr_o;
  logic [2:0] scan_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] cmem [8];
  logic       fmem [8];

  always #2 clk_i = ~clk_i;

  disp_clr_seq u_disp_clr_seq (.*);

  always @(posedge clk_i) begin
    for (int i = 0; i < 8; i++) begin
      if (char_we_o[i])  cmem[i] <= char_wdata_o;
      if (flash_we_o[i]) fmem[i] <= flash_wdata_o;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic host(input bit en, input logic [1:0] sel, input logic [2:0] a,
                      input logic [7:0] d);
    wr_en_i = en; wr_sel_i = sel; wr_addr_i = a; wr_data_i = d;
  endtask

  task automatic t_reset();
    step(); rst_ni = 1'b0; #1;
    chk("R1 busy", busy_o, 1); chk("R1 ctrl", ctrl_o, 0); chk("R1 scan", scan_o, 0);
    step(); step(); rst_ni = 1'b1; #1;
    chk("R2 mask0", char_we_o, 8'h07); chk("R2 fmask0", flash_we_o, 8'h07);
    chk("R2 data", char_wdata_o, 8'h20); chk("R2 fdata", flash_wdata_o, 0);
    step(); #1; chk("R2 mask1", char_we_o, 8'h38);
    step(); #1; chk("R2 mask2", char_we_o, 8'hC0); chk("R2 busy", busy_o, 1);
    step(); #1; chk("R2 done", busy_o, 0); chk("R2 we idle", char_we_o, 0);
    chk("R10 scan", scan_o, 3);
  endtask

  task automatic t_host();
    step(); host(1, 2'd1, 3'd4, 8'h55); #1;
    chk("R9 char we", char_we_o, 8'h10); chk("R9 char data", char_wdata_o, 8'h55);
    chk("R9 no flash", flash_we_o, 0);
    step(); host(1, 2'd2, 3'd2, 8'h03); #1;
    chk("R9 flash we", flash_we_o, 8'h04); chk("R9 flash data", flash_wdata_o, 1);
    for (int i = 0; i < 8; i++) begin
      step(); host(1, 2'd1, 3'(i), 8'h41 + 8'(i));
      step(); host(1, 2'd2, 3'(i), 8'h01);
    end
    step(); host(1, 2'd3, 3'd0, 8'h09);
    step(); host(1, 2'd0, 3'd0, 8'h05);
    step(); host(0, 2'd0, 3'd0, 8'h00); #1;
    chk("R9 udc", udc_addr_o, 9); chk("R3 ctrl", ctrl_o, 8'h05); chk("R3 idle", busy_o, 0);
    chk("R9 mem", cmem[7], 8'h48);
  endtask

  task automatic t_clear();
    logic [2:0] sc;
    step(); host(1, 2'd0, 3'd0, 8'h83); #1;
    chk("R3 not yet", busy_o, 0);
    step(); host(1, 2'd1, 3'd5, 8'h41); #1;
    chk("R3 busy", busy_o, 1); chk("R3 ctrl", ctrl_o, 8'h83);
    chk("R7 mask", char_we_o, 8'h07); chk("R7 data", char_wdata_o, 8'h20);
    step(); host(1, 2'd3, 3'd0, 8'h0F); #1;
    chk("R7 mask1", char_we_o, 8'h38);
    step(); host(0, 2'd0, 3'd0, 8'h00); #1;
    chk("R3 mask2", char_we_o, 8'hC0); sc = scan_o;
    step(); #1;
    chk("R4 busy end", busy_o, 0); chk("R4 ctrl", ctrl_o, 8'h03);
    chk("R5 udc", udc_addr_o, 9); chk("R5 scan", scan_o, 3'(sc + 3'd1));
    for (int i = 0; i < 8; i++) begin
      chk("R11 char", cmem[i], 8'h20); chk("R11 flash", fmem[i], 0);
    end
  endtask

  task automatic t_clr_in_rst();
    step(); rst_ni = 1'b0; host(1, 2'd0, 3'd0, 8'h80);
    step(); rst_ni = 1'b1; #1; chk("R8 busy", busy_o, 1);
    step(); step(); host(0, 2'd0, 3'd0, 8'h00);
    step(); #1;
    chk("R8 idle", busy_o, 0); chk("R8 ctrl", ctrl_o, 0);
    chk("R6 udc", udc_addr_o, 9);
    for (int i = 0; i < 7; i++) step();
    #1; chk("R10 wrap", scan_o, 2);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    t_reset();
    t_host();
    t_clear();
    t_clr_in_rst();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule